// File: doc/BRIEF.md
# Port I/O Permission Bitmap Checker

This block decides whether a guest's port I/O access must be trapped to the hypervisor. A bitmap in memory holds one bit per port number. When the I/O trap enable is set, the block reads two consecutive bitmap bytes and puts them together into a 16-bit window. A mask built from the access size, shifted to the port's bit position, is then tested against that window. A multi-byte access near the end of a byte can therefore hit on a permission bit that sits in the following byte.

The processor pulses `start` with the port number, the access parameter word, the bitmap base address, the current instruction pointer and the instruction length. All of these are captured on that edge. The block issues two byte reads through a request/acknowledge memory port. It then raises `done` for one cycle, together with the hit flag and the exit information. When the trap enable is clear, the block answers at once with a miss and does not touch memory.

Top module: `ioperm_guard`

## Requirements
- R1: When `io_trap_en` is low at the `start` edge, `done` rises in the very next cycle with `hit` low and no memory request is made.
- R2: When `io_trap_en` is high, two byte reads are made in this order: first at `bitmap_base + port[15:3]` (the low byte), then at that address plus one (the high byte). The window is {high byte, low byte}.
- R3: Once `mem_req` is raised, it stays high with an unchanged `mem_addr` until the cycle in which `mem_ack` is high. Read data is taken on that edge.
- R4: The access size is `acc_param[6:4]` (1 = byte, 2 = word, 4 = dword; 0 tests nothing). The test mask is `(1 << size) - 1` shifted left by `port[2:0]`. `hit` is high when any masked window bit is set. For example, port mod 8 = 7 with size 4 tests bit 7 of the low byte and bits 2:0 of the high byte.
- R5: On a hit, `exit_code` is `EXIT_IO_CODE` (default 0x7B). `exit_info1` is the zero-extended `acc_param` OR'd with `port << 16`. `exit_info2` is `cur_ip + insn_len`.
- R6: On a miss, `exit_code`, `exit_info1` and `exit_info2` are zero while `done` is high.
- R7: `done` is high for exactly one cycle per accepted access. While `done` is low, `hit` and every exit field are zero. A `start` pulse arriving while `busy` is high is ignored and produces no extra reads and no extra `done`.
- R8: After reset, `done`, `busy`, `hit` and `mem_req` are low.
- R9: The port, parameter, base, pointer and length are captured at the accepting `start` edge. Later changes on those inputs do not affect the reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check (taken only when not busy) |
| io_trap_en | input | 1 | I/O intercept enable from the general intercept vector |
| port | input | 16 | Port number of the access |
| acc_param | input | 32 | Access parameter word, size in bits 6:4 |
| bitmap_base | input | ADDR_W | Byte address of the permission bitmap |
| cur_ip | input | 64 | Instruction pointer of the I/O instruction |
| insn_len | input | LEN_W | Length of the I/O instruction in bytes |
| busy | output | 1 | A check is in progress |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Access is trapped |
| exit_code | output | EXIT_W | Exit reason code on a hit |
| exit_info1 | output | 64 | Parameter word merged with port number |
| exit_info2 | output | 64 | Next instruction pointer |

## Verification
Some rules are checked by assertions on every cycle. These are the memory handshake (request held with a stable address until acknowledged, second address one above the first) and the single-cycle `done` with all outputs zero around it. They also cover the immediate miss when trapping is disabled, the absence of memory traffic while idle, and the fixed exit code on every hit. Other behaviour can only be shown by the bench's scenarios, because it needs a known bitmap. This covers whether the size mask lands on the right bits, the straddling dword and word cases at bit position 7, the zero-size case, the exit information values, input capture at the start edge, and the dropping of a start pulse while busy.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

    localparam int unsigned PORT_W   = 16;
    localparam int unsigned PARAM_W  = 32;
    localparam int unsigned INFO_W   = 64;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WIN_W    = 2 * BYTE_W;
    localparam int unsigned SIZE_LSB = 4;
    localparam int unsigned SIZE_W   = 3;
    localparam int unsigned BPOS_W   = 3;
    localparam int unsigned PORT_SH  = 16;

    typedef enum logic [0:0] {
        CT_IDLE  = 1'b0,
        CT_FETCH = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        FX_IDLE = 2'd0,
        FX_LO   = 2'd1,
        FX_HI   = 2'd2,
        FX_DONE = 2'd3
    } fetch_state_e;

    typedef struct packed {
        logic [PORT_W-1:0]  port;
        logic [PARAM_W-1:0] param;
        logic [INFO_W-1:0]  next_ip;
    } io_req_t;

    function automatic logic [SIZE_W-1:0] size_of(input logic [PARAM_W-1:0] p);
        return p[SIZE_LSB +: SIZE_W];
    endfunction

    function automatic logic [WIN_W-1:0] window_mask(input logic [SIZE_W-1:0] sz,
                                                     input logic [BPOS_W-1:0] bpos);
        logic [WIN_W-1:0] ones;
        ones = (WIN_W'(1) << sz) - WIN_W'(1);
        return ones << bpos;
    endfunction

endpackage

// File: rtl/ioperm_word_fetch.sv
module ioperm_word_fetch
    import ioperm_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [ADDR_W-1:0]     first_addr,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_ack,
    input  logic [BYTE_W-1:0]     mem_rdata,
    output logic                  word_valid,
    output logic [WIN_W-1:0]      word
);

    fetch_state_e        st_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   lo_q;
    logic [BYTE_W-1:0]   hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FX_IDLE;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            case (st_q)
                FX_IDLE: begin
                    if (go) begin
                        addr_q <= first_addr;
                        st_q   <= FX_LO;
                    end
                end
                FX_LO: begin
                    if (mem_ack) begin
                        lo_q   <= mem_rdata;
                        addr_q <= addr_q + ADDR_W'(1);
                        st_q   <= FX_HI;
                    end
                end
                FX_HI: begin
                    if (mem_ack) begin
                        hi_q <= mem_rdata;
                        st_q <= FX_DONE;
                    end
                end
                default: st_q <= FX_IDLE;
            endcase
        end
    end

    assign mem_req    = (st_q == FX_LO) || (st_q == FX_HI);
    assign mem_addr   = addr_q;
    assign word_valid = (st_q == FX_DONE);
    assign word       = {hi_q, lo_q};

    // R3: an unanswered request keeps its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2: the high byte is read one address above the low byte
    p_hi_addr_next_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == FX_LO && mem_ack) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R2: exactly two acknowledged reads precede the assembled word
    p_valid_after_hi_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(word_valid) |-> ($past(mem_ack) && $past(st_q) == FX_HI));

endmodule

// File: rtl/ioperm_hit_eval.sv
module ioperm_hit_eval
    import ioperm_pkg::*;
(
    input  logic [WIN_W-1:0]  word,
    input  logic [SIZE_W-1:0] size,
    input  logic [BPOS_W-1:0] bpos,
    output logic              hit
);

    logic [WIN_W-1:0] mask;
    logic [WIN_W-1:0] hit_bits;

    assign mask = window_mask(size, bpos);

    for (genvar i = 0; i < WIN_W; i++) begin : g_bit
        assign hit_bits[i] = word[i] & mask[i];
    end

    assign hit = |hit_bits;

    // R4: a zero-size access can never hit
    always_comb begin
        if (size == '0) begin
            a_zero_size_r4: assert (!hit);
        end
    end

endmodule

// File: rtl/ioperm_exit_fmt.sv
module ioperm_exit_fmt
    import ioperm_pkg::*;
#(
    parameter int unsigned EXIT_W       = 32,
    parameter int unsigned EXIT_IO_CODE = 'h7B
) (
    input  io_req_t            req,
    input  logic               hit,
    output logic [EXIT_W-1:0]  code,
    output logic [INFO_W-1:0]  info1,
    output logic [INFO_W-1:0]  info2
);

    always_comb begin
        code  = '0;
        info1 = '0;
        info2 = '0;
        if (hit) begin
            code  = EXIT_W'(EXIT_IO_CODE);
            info1 = INFO_W'(req.param) | (INFO_W'(req.port) << PORT_SH);
            info2 = req.next_ip;
        end
    end

endmodule

// File: rtl/ioperm_guard.sv
module ioperm_guard
    import ioperm_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned LEN_W        = 4,
    parameter int unsigned EXIT_W       = 32,
    parameter int unsigned EXIT_IO_CODE = 'h7B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 io_trap_en,
    input  logic [15:0]          port,
    input  logic [31:0]          acc_param,
    input  logic [ADDR_W-1:0]    bitmap_base,
    input  logic [63:0]          cur_ip,
    input  logic [LEN_W-1:0]     insn_len,
    output logic                 busy,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [7:0]           mem_rdata,
    output logic                 done,
    output logic                 hit,
    output logic [EXIT_W-1:0]    exit_code,
    output logic [63:0]          exit_info1,
    output logic [63:0]          exit_info2
);

    localparam int unsigned IDX_W = PORT_W - BPOS_W;

    ctl_state_e          st_q;
    io_req_t             req_q;
    logic                fetch_go;
    logic [ADDR_W-1:0]   first_addr;
    logic                word_valid;
    logic [WIN_W-1:0]    word;
    logic                hit_c;
    logic [EXIT_W-1:0]   code_c;
    logic [INFO_W-1:0]   info1_c;
    logic [INFO_W-1:0]   info2_c;

    logic                done_q;
    logic                hit_q;
    logic [EXIT_W-1:0]   code_q;
    logic [INFO_W-1:0]   info1_q;
    logic [INFO_W-1:0]   info2_q;

    assign fetch_go   = (st_q == CT_IDLE) && start && io_trap_en;
    assign first_addr = bitmap_base + ADDR_W'(port[PORT_W-1 -: IDX_W]);

    ioperm_word_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .go         (fetch_go),
        .first_addr (first_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .word_valid (word_valid),
        .word       (word)
    );

    ioperm_hit_eval u_eval (
        .word (word),
        .size (size_of(req_q.param)),
        .bpos (req_q.port[BPOS_W-1:0]),
        .hit  (hit_c)
    );

    ioperm_exit_fmt #(.EXIT_W(EXIT_W), .EXIT_IO_CODE(EXIT_IO_CODE)) u_fmt (
        .req   (req_q),
        .hit   (hit_c),
        .code  (code_c),
        .info1 (info1_c),
        .info2 (info2_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CT_IDLE;
            req_q   <= '0;
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
            code_q  <= '0;
            info1_q <= '0;
            info2_q <= '0;
        end else begin
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
            code_q  <= '0;
            info1_q <= '0;
            info2_q <= '0;
            case (st_q)
                CT_IDLE: begin
                    if (start) begin
                        req_q.port    <= port;
                        req_q.param   <= acc_param;
                        req_q.next_ip <= cur_ip + INFO_W'(insn_len);
                        if (io_trap_en) begin
                            st_q <= CT_FETCH;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (word_valid) begin
                        done_q  <= 1'b1;
                        hit_q   <= hit_c;
                        code_q  <= code_c;
                        info1_q <= info1_c;
                        info2_q <= info2_c;
                        st_q    <= CT_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy       = (st_q != CT_IDLE);
    assign done       = done_q;
    assign hit        = hit_q;
    assign exit_code  = code_q;
    assign exit_info1 = info1_q;
    assign exit_info2 = info2_q;

    // R1: disabled trapping answers next cycle with a miss
    p_off_fast_miss_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !io_trap_en) |=> (done && !hit && !busy));

    // R1: no memory traffic while idle
    p_idle_no_req_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: outputs quiet outside the strobe
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!hit && exit_code == '0 && exit_info1 == '0 && exit_info2 == '0));

    // R6: a miss reports zero exit information
    p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (exit_code == '0 && exit_info1 == '0 && exit_info2 == '0));

    // R5: every hit carries the I/O exit code
    p_hit_code_r5: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> (exit_code == EXIT_W'(EXIT_IO_CODE)));

endmodule

// File: tb/ioperm_guard_tb_top.sv
module ioperm_guard_tb_top;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned LEN_W  = 4;
    localparam logic [31:0] BASE   = 32'h0000_4000;
    localparam logic [31:0] IO_EXIT = 32'h7B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        io_trap_en = 1'b0;
    logic [15:0] port = '0;
    logic [31:0] acc_param = '0;
    logic [31:0] bitmap_base = BASE;
    logic [63:0] cur_ip = '0;
    logic [3:0]  insn_len = '0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [7:0]  mem_rdata;
    logic        done;
    logic        hit;
    logic [31:0] exit_code;
    logic [63:0] exit_info1;
    logic [63:0] exit_info2;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]  bmap [0:511];
    int          ack_delay = 0;
    int          wait_cnt;
    int          txn_n;
    logic [31:0] txn_log [0:255];

    always #5 clk = ~clk;

    ioperm_guard #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .io_trap_en(io_trap_en),
        .port(port), .acc_param(acc_param), .bitmap_base(bitmap_base),
        .cur_ip(cur_ip), .insn_len(insn_len), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .hit(hit), .exit_code(exit_code),
        .exit_info1(exit_info1), .exit_info2(exit_info2)
    );

    // memory responder with programmable acknowledge delay
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wait_cnt  <= 0;
            txn_n     <= 0;
        end else begin
            if (mem_req && mem_ack) begin
                txn_log[txn_n[7:0]] <= mem_addr;
                txn_n <= txn_n + 1;
            end
            if (mem_req && !mem_ack) begin
                if (wait_cnt >= ack_delay) begin
                    mem_ack   <= 1'b1;
                    mem_rdata <= bmap[9'(mem_addr - BASE)];
                    wait_cnt  <= 0;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [15:0] p, input logic [31:0] prm);
        logic [15:0] w;
        logic [15:0] m;
        int off;
        off = int'(p[15:3]);
        w = {bmap[off + 1], bmap[off]};
        m = ((16'd1 << prm[6:4]) - 16'd1) << p[2:0];
        return |(w & m);
    endfunction

    task automatic clear_map();
        for (int i = 0; i < 512; i++) bmap[i] = 8'h00;
    endtask

    task automatic set_port_bit(input int p);
        bmap[p / 8] = bmap[p / 8] | (8'd1 << (p % 8));
    endtask

    // one full access; checks exit fields, read addresses and latency
    task automatic do_access(input logic [15:0] p, input logic [31:0] prm,
                             input logic [63:0] ip, input logic [3:0] len,
                             input logic en, output logic got_hit,
                             output int cycles, output int n_txn);
        int t0;
        logic exp_h;
        t0 = txn_n;
        port = p; acc_param = prm; cur_ip = ip; insn_len = len; io_trap_en = en;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
        got_hit = hit;
        n_txn = txn_n - t0;
        exp_h = en ? model_hit(p, prm) : 1'b0;
        check("R4", "hit", 64'(hit), 64'(exp_h));
        if (exp_h) begin
            check("R5", "exit_code", 64'(exit_code), 64'(IO_EXIT));
            check("R5", "exit_info1", exit_info1, 64'(prm) | (64'(p) << 16));
            check("R5", "exit_info2", exit_info2, ip + 64'(len));
        end else begin
            check("R6", "exit_code", 64'(exit_code), 64'h0);
            check("R6", "exit_info1", exit_info1, 64'h0);
            check("R6", "exit_info2", exit_info2, 64'h0);
        end
        if (en && n_txn == 2) begin
            check("R2", "low byte addr", 64'(txn_log[8'(t0)]), 64'(BASE + 32'(p[15:3])));
            check("R2", "high byte addr", 64'(txn_log[8'(t0 + 1)]), 64'(BASE + 32'(p[15:3]) + 32'd1));
        end
        @(negedge clk);
        check("R7", "done width", 64'(done), 64'h0);
    endtask

    task automatic t_reset();
        check("R8", "done after reset", 64'(done), 64'h0);
        check("R8", "busy after reset", 64'(busy), 64'h0);
        check("R8", "mem_req after reset", 64'(mem_req), 64'h0);
        check("R8", "hit after reset", 64'(hit), 64'h0);
    endtask

    task automatic t_trap_off();
        logic h; int c; int n;
        clear_map();
        set_port_bit(16'h0060);
        do_access(16'h0060, 32'h10, 64'h1000, 4'd2, 1'b0, h, c, n);
        check("R1", "latency when disabled", 64'(c), 64'd1);
        check("R1", "reads when disabled", 64'(n), 64'd0);
        check("R1", "hit when disabled", 64'(h), 64'd0);
    endtask

    task automatic t_byte_hit();
        logic h; int c; int n;
        clear_map();
        set_port_bit(16'h0021);
        do_access(16'h0021, 32'h0000_0011, 64'hFFFF_0000_0000_1234, 4'd1, 1'b1, h, c, n);
        check("R4", "byte hit", 64'(h), 64'd1);
        check("R2", "read count", 64'(n), 64'd2);
    endtask

    task automatic t_byte_miss();
        logic h; int c; int n;
        clear_map();
        set_port_bit(16'h0022);
        set_port_bit(16'h0020);
        do_access(16'h0021, 32'h0000_0010, 64'h2000, 4'd1, 1'b1, h, c, n);
        check("R4", "neighbour bits do not hit", 64'(h), 64'd0);
    endtask

    task automatic t_straddle_dword();
        logic h; int c; int n;
        clear_map();
        set_port_bit(16'h01F7 + 3);
        do_access(16'h01F7, 32'h0000_0048, 64'h3000, 4'd2, 1'b1, h, c, n);
        check("R4", "dword straddle hits next byte", 64'(h), 64'd1);
        clear_map();
        set_port_bit(16'h01F7 + 4);
        do_access(16'h01F7, 32'h0000_0040, 64'h3000, 4'd2, 1'b1, h, c, n);
        check("R4", "dword stops at size", 64'(h), 64'd0);
    endtask

    task automatic t_straddle_word();
        logic h; int c; int n;
        clear_map();
        set_port_bit(16'h0A0F + 1);
        do_access(16'h0A0F, 32'h0000_0021, 64'h0000_00FF_FFFF_FFFF, 4'd15, 1'b1, h, c, n);
        check("R4", "word straddle hit", 64'(h), 64'd1);
    endtask

    task automatic t_size_zero();
        logic h; int c; int n;
        for (int i = 0; i < 512; i++) bmap[i] = 8'hFF;
        do_access(16'h0104, 32'h0000_0001, 64'h4000, 4'd1, 1'b1, h, c, n);
        check("R4", "size zero never hits", 64'(h), 64'd0);
        check("R2", "size zero still reads", 64'(n), 64'd2);
    endtask

    task automatic t_slow_ack();
        logic h; int c; int n;
        clear_map();
        set_port_bit(16'h0333);
        ack_delay = 3;
        do_access(16'h0332, 32'h0000_0020, 64'h5000, 4'd3, 1'b1, h, c, n);
        ack_delay = 0;
        check("R3", "hit with slow acknowledge", 64'(h), 64'd1);
        check("R3", "reads with slow acknowledge", 64'(n), 64'd2);
    endtask

    task automatic t_capture();
        int t0; int cyc;
        clear_map();
        set_port_bit(16'h0050);
        t0 = txn_n;
        port = 16'h0050; acc_param = 32'h0000_0010; cur_ip = 64'h7000;
        insn_len = 4'd2; io_trap_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        port = 16'h0090; acc_param = 32'h0000_0040; cur_ip = 64'h9999; insn_len = 4'd9;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check("R9", "hit from captured port", 64'(hit), 64'd1);
        check("R9", "info1 from captured inputs", exit_info1, 64'h0050_0010);
        check("R9", "info2 from captured inputs", exit_info2, 64'h7002);
        check("R9", "low addr from captured port", 64'(txn_log[8'(t0)]), 64'(BASE + 32'h0A));
        @(negedge clk);
    endtask

    task automatic t_busy_start();
        int t0; int cyc; int dones;
        clear_map();
        set_port_bit(16'h0008);
        t0 = txn_n;
        port = 16'h0008; acc_param = 32'h0000_0010; cur_ip = 64'h100;
        insn_len = 4'd1; io_trap_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R7", "busy during fetch", 64'(busy), 64'd1);
        port = 16'h0100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 20; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        check("R7", "one done for busy start", 64'(dones), 64'd1);
        check("R7", "reads for busy start", 64'(txn_n - t0), 64'd2);
    endtask

    initial begin
        clear_map();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trap_off();
        t_byte_hit();
        t_byte_miss();
        t_straddle_dword();
        t_straddle_word();
        t_size_zero();
        t_slow_ack();
        t_capture();
        t_busy_start();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule